// File: doc/BRIEF.md
# Instruction Prefetch Byte Queue

This block is a four-entry, byte-wide buffer that sits between a bus fetch unit and an instruction decoder. The fetch side deposits one byte per accepted write. The decoder side asks for one byte per request and sees a valid flag. When that flag is low, the request stalls.

Two 2-bit positions track the entries: the oldest unread entry and the next free slot. Both wrap modulo four. A separate empty flip-flop resolves the case where the two positions are equal, which can mean either empty or full. The fill count comes from the position difference together with that flag.

A flush input discards everything in one cycle. A correction output subtracts the fill count from the fetch-side instruction pointer. This gives the address of the next byte the decoder will consume.

Top module: `prefetch_byte_queue`

## Requirements
- R1: After reset the queue is empty: `fill_o` is 0, `rd_valid_o` is 0 and `wr_ready_o` is 1.
- R2: Bytes leave in the order they were accepted. Each accepted write (`wr_valid_i` and `wr_ready_o` both high at a rising edge) stores exactly one byte.
- R3: Both positions wrap from 3 to 0, and byte order is kept across any number of wraps.
- R4: `fill_o` (3 bits, range 0 to 4) equals accepted writes minus accepted reads since the last reset or flush. It reads 4 when the queue is full and 0 when it is empty.
- R5: While the queue holds no byte, `rd_valid_o` is 0 and a request consumes nothing. The stall ends on the cycle after a byte is accepted.
- R6: A flush empties the queue by the next cycle (`fill_o` 0, `rd_valid_o` 0). It takes priority over a write or read in the same cycle, so such a write is dropped.
- R7: `corr_ip_o` equals `fetch_ip_i` minus `fill_o`, modulo 2^16, in the same cycle.
- R8: `wr_ready_o` is 0 while 4 bytes are held. A write presented then leaves the count and the contents unchanged.
- R9: A read and a write accepted together leave `fill_o` unchanged. A full queue that receives a read and a write together drops to 3.
- R10: There is no combinational bypass. A write and a read presented together to an empty queue give `rd_valid_o` 0 in that cycle, and the byte becomes readable on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| flush_i | input | 1 | Discard all contents |
| wr_valid_i | input | 1 | Fetch side offers a byte |
| wr_data_i | input | 8 | Fetched byte |
| wr_ready_o | output | 1 | Queue can accept a byte |
| rd_req_i | input | 1 | Decoder requests a byte |
| rd_valid_o | output | 1 | Head byte is valid; low means stall |
| rd_data_o | output | 8 | Head byte |
| fill_o | output | 3 | Number of bytes held (0 to 4) |
| fetch_ip_i | input | 16 | Fetch-side instruction pointer |
| corr_ip_o | output | 16 | Fetch pointer minus fill count |

## Verification
The bench targets the full/empty aliasing. A design that dropped the empty flag, or set it at the wrong moment, would report 0 bytes when it holds 4, or the reverse. Writes into a full queue are driven to catch an overwrite of the head byte. A write and a read are presented together to an empty queue to catch a bypass that leaks a stale entry. Flushes are issued together with writes, and a design without flush priority would keep the dropped byte. Long random runs wrap the positions many times, which exposes any wrap or ordering error in the stream of head bytes and in the corrected pointer.

// File: rtl/pq_pkg.sv
package pq_pkg;
    localparam int DW    = 8;
    localparam int DEPTH = 4;
    localparam int PW    = $clog2(DEPTH);
    localparam int CW    = PW + 1;
    localparam int AW    = 16;

    typedef struct packed {
        logic [PW-1:0] rpos;
        logic [PW-1:0] wpos;
        logic          empty;
    } ctrl_t;
endpackage

// File: rtl/pq_len.sv
module pq_len
    import pq_pkg::*;
(
    input  logic [PW-1:0] rpos_i,
    input  logic [PW-1:0] wpos_i,
    input  logic          empty_i,
    output logic [CW-1:0] fill_o
);
    logic [PW-1:0] diff;

    always_comb begin
        diff = wpos_i - rpos_i;
        if (diff == '0) begin
            fill_o = empty_i ? '0 : CW'(DEPTH);
        end else begin
            fill_o = {1'b0, diff};
        end
    end
endmodule

// File: rtl/pq_ctrl.sv
module pq_ctrl
    import pq_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush_i,
    input  logic          wr_en_i,
    input  logic          rd_en_i,
    input  logic [CW-1:0] fill_i,
    output ctrl_t         st_o
);
    ctrl_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (flush_i) begin
            st_d.rpos  = '0;
            st_d.wpos  = '0;
            st_d.empty = 1'b1;
        end else begin
            if (wr_en_i) begin
                st_d.wpos  = st_q.wpos + 1'b1;
                st_d.empty = 1'b0;
            end
            if (rd_en_i) begin
                st_d.rpos = st_q.rpos + 1'b1;
                if (!wr_en_i && fill_i == CW'(1)) begin
                    st_d.empty = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{rpos: '0, wpos: '0, empty: 1'b1};
        end else begin
            st_q <= st_d;
        end
    end

    assign st_o = st_q;

    assert_rpos_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!flush_i && rd_en_i && st_q.rpos == PW'(DEPTH-1)) |=> (st_q.rpos == '0));

    assert_wpos_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!flush_i && wr_en_i && st_q.wpos == PW'(DEPTH-1)) |=> (st_q.wpos == '0));

    assert_flush_resets_R6: assert property (@(posedge clk) disable iff (!rst_n)
        flush_i |=> (st_q.empty && st_q.rpos == '0 && st_q.wpos == '0));
endmodule

// File: rtl/pq_store.sv
module pq_store
    import pq_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en_i,
    input  logic [PW-1:0] wpos_i,
    input  logic [DW-1:0] wr_data_i,
    input  logic [PW-1:0] rpos_i,
    output logic [DW-1:0] rd_data_o
);
    logic [DW-1:0] mem_q [DEPTH];
    logic [DW-1:0] mem_d [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_entry
        always_comb begin
            mem_d[g] = mem_q[g];
            if (wr_en_i && wpos_i == PW'(g)) begin
                mem_d[g] = wr_data_i;
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                mem_q[g] <= '0;
            end else begin
                mem_q[g] <= mem_d[g];
            end
        end
    end

    assign rd_data_o = mem_q[rpos_i];
endmodule

// File: rtl/prefetch_byte_queue.sv
module prefetch_byte_queue
    import pq_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush_i,
    input  logic          wr_valid_i,
    input  logic [7:0]    wr_data_i,
    output logic          wr_ready_o,
    input  logic          rd_req_i,
    output logic          rd_valid_o,
    output logic [7:0]    rd_data_o,
    output logic [2:0]    fill_o,
    input  logic [15:0]   fetch_ip_i,
    output logic [15:0]   corr_ip_o
);
    ctrl_t         st;
    logic [CW-1:0] fill;
    logic          wr_en;
    logic          rd_en;

    assign wr_ready_o = (fill != CW'(DEPTH));
    assign rd_valid_o = !st.empty;
    assign wr_en      = wr_valid_i && wr_ready_o && !flush_i;
    assign rd_en      = rd_req_i && rd_valid_o && !flush_i;
    assign fill_o     = fill;
    assign corr_ip_o  = fetch_ip_i - AW'(fill);

    pq_len u_len (
        .rpos_i  (st.rpos),
        .wpos_i  (st.wpos),
        .empty_i (st.empty),
        .fill_o  (fill)
    );

    pq_ctrl u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .flush_i (flush_i),
        .wr_en_i (wr_en),
        .rd_en_i (rd_en),
        .fill_i  (fill),
        .st_o    (st)
    );

    pq_store u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (wr_en),
        .wpos_i    (st.wpos),
        .wr_data_i (wr_data_i),
        .rpos_i    (st.rpos),
        .rd_data_o (rd_data_o)
    );

    assert_full_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_o == 3'd4) |-> !wr_ready_o);

    assert_full_write_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid_i && !wr_ready_o && !rd_req_i && !flush_i) |=> $stable(fill_o));

    assert_stall_when_empty_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_valid_o |-> (fill_o == 3'd0));

    assert_flush_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
        flush_i |=> (fill_o == 3'd0 && !rd_valid_o));

    assert_balanced_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!flush_i && wr_valid_i && wr_ready_o && rd_req_i && rd_valid_o) |=> $stable(fill_o));

    assert_no_bypass_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!flush_i && !rd_valid_o && wr_valid_i) |-> (fill_o == 3'd0) ##1 (rd_valid_o && fill_o == 3'd1));

    assert_fill_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        fill_o <= 3'd4);
endmodule

// File: tb/prefetch_byte_queue_tb.sv
module prefetch_byte_queue_tb;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        flush_i;
    logic        wr_valid_i;
    logic [7:0]  wr_data_i;
    logic        wr_ready_o;
    logic        rd_req_i;
    logic        rd_valid_o;
    logic [7:0]  rd_data_o;
    logic [2:0]  fill_o;
    logic [15:0] fetch_ip_i;
    logic [15:0] corr_ip_o;

    int n_chk = 0;
    int n_bad = 0;
    logic [7:0] mdl [$];

    always #5 clk = ~clk;

    prefetch_byte_queue u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .flush_i    (flush_i),
        .wr_valid_i (wr_valid_i),
        .wr_data_i  (wr_data_i),
        .wr_ready_o (wr_ready_o),
        .rd_req_i   (rd_req_i),
        .rd_valid_o (rd_valid_o),
        .rd_data_o  (rd_data_o),
        .fill_o     (fill_o),
        .fetch_ip_i (fetch_ip_i),
        .corr_ip_o  (corr_ip_o)
    );

    function automatic logic [15:0] exp_corr(input logic [15:0] ip, input int cnt);
        return ip - 16'(cnt);
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic compare_outputs();
        int sz = mdl.size();
        chk("R4 fill count", 32'(fill_o), 32'(sz));
        chk("R5 valid/stall", 32'(rd_valid_o), 32'(sz > 0));
        chk("R8 ready", 32'(wr_ready_o), 32'(sz < 4));
        chk("R7 corrected pointer", 32'(corr_ip_o), 32'(exp_corr(fetch_ip_i, sz)));
        if (sz > 0) chk("R2 R3 head byte order", 32'(rd_data_o), 32'(mdl[0]));
    endtask

    task automatic step(input logic fl, input logic wv, input logic rr,
                        input logic [7:0] d, input logic [15:0] ip);
        logic wacc;
        logic racc;
        @(negedge clk);
        flush_i    = fl;
        wr_valid_i = wv;
        wr_data_i  = d;
        rd_req_i   = rr;
        fetch_ip_i = ip;
        #1;
        compare_outputs();
        wacc = wv && (mdl.size() < 4);
        racc = rr && (mdl.size() > 0);
        @(posedge clk);
        if (fl) begin
            mdl.delete();
        end else begin
            if (racc) void'(mdl.pop_front());
            if (wacc) mdl.push_back(d);
        end
    endtask

    initial begin
        #2000000;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        rst_n = 1'b0; flush_i = 0; wr_valid_i = 0; wr_data_i = 0; rd_req_i = 0; fetch_ip_i = 16'h1000;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        chk("R1 reset fill", 32'(fill_o), 32'd0);
        chk("R1 reset valid", 32'(rd_valid_o), 32'd0);
        chk("R1 reset ready", 32'(wr_ready_o), 32'd1);

        // R10 write and read together on empty queue: no bypass
        step(0, 1, 1, 8'hA1, 16'h2000);
        step(0, 0, 1, 8'h00, 16'h2001);
        // R5 read on empty stalls
        step(0, 0, 1, 8'h00, 16'h2001);
        // Fill to 4, R8 write while full ignored
        for (int i = 0; i < 5; i++) step(0, 1, 0, 8'hB0 + 8'(i), 16'h3000 + 16'(i));
        step(0, 1, 0, 8'hEE, 16'h3005);
        // R9 read and write together on full: count goes to 3
        step(0, 1, 1, 8'hCC, 16'h3006);
        // R9 balanced traffic on partial queue
        for (int i = 0; i < 6; i++) step(0, 1, 1, 8'hD0 + 8'(i), 16'h3010 + 16'(i));
        // R6 flush with a simultaneous write and read
        step(1, 1, 1, 8'hF1, 16'h4000);
        step(0, 0, 1, 8'h00, 16'h4001);
        // R6 flush when full
        for (int i = 0; i < 4; i++) step(0, 1, 0, 8'h60 + 8'(i), 16'h4100);
        step(1, 0, 0, 8'h00, 16'h4200);
        step(0, 0, 0, 8'h00, 16'h4201);

        // Constrained random traffic, R2 R3 R4 R7 over many wraps
        for (int i = 0; i < 3000; i++) begin
            logic fl;
            logic wv;
            logic rr;
            fl = ($urandom % 40) == 0;
            wv = ($urandom % 100) < ((i / 500) % 2 == 0 ? 70 : 35);
            rr = ($urandom % 100) < ((i / 500) % 2 == 0 ? 35 : 70);
            step(fl, wv, rr, 8'($urandom), 16'($urandom));
        end
        step(0, 0, 0, 8'h00, 16'h0000);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule